// File: doc/BRIEF.md
# Performance Counter Bank

This block holds a configurable number of 32-bit event counters and one 64-bit cycle counter for a cache or interconnect subsystem. Software reaches every counter and control bitmask through a simple synchronous register port (address, write data, write strobe, registered read data). Each event counter adds one for every pulse on its own event input while the bank is globally enabled and the counter is individually enabled. The cycle counter advances on every clock under the same two conditions.

Counter enable, overflow-interrupt enable and overflow status are each kept as a 32-bit bitmask, with a set address and a clear address. Event counter n owns bit n, and the cycle counter always owns bit 31. A counter that wraps from all-ones to zero sets its sticky overflow bit. A single level interrupt is raised while any overflow bit is set together with its interrupt-enable bit. Software can load any counter directly, for example to mid-range, so that an overflow arrives after a known number of events.

Top module: `pcb_bank`

## Requirements
- R1: After a synchronous reset every counter, the global enable, and the counter-enable, interrupt-enable and overflow bitmasks are zero, and `irq` is low.
- R2: The control register is at address 0x00. Reading it returns the global enable in bit 0 and the number of event counters (not counting the cycle counter) in bits 15:11. Writing it loads bit 0 into the global enable.
- R3: The bitmask addresses are 0x01/0x02 for counter-enable set/clear, 0x03/0x04 for interrupt-enable set/clear and 0x05/0x06 for overflow set/clear. Writing a 1 sets or clears that bit, and a 0 bit leaves it unchanged. Reading either address of a pair returns the current mask. Only bits 0..NUM_EVT-1 and bit 31 exist, and all other bits read 0.
- R4: Event counter n is at address 0x10+n. It adds one on each clock edge where its event input is high, the global enable is 1 and mask bit n is 1. Otherwise it holds its value.
- R5: The cycle counter adds one on every clock edge where the global enable is 1 and mask bit 31 is 1. Otherwise it holds its value.
- R6: A write to a counter address loads the written value. The cycle counter is loaded in halves: the low word is at 0x08 and the high word at 0x09. A load takes priority over counting in the same cycle.
- R7: Writing exactly 0x6 to the control register zeroes every counter. Because bit 0 of that value is 0, the write also clears the global enable.
- R8: A counter that advances from all-ones to zero sets its overflow bit. The bit stays set until an overflow-clear write names it.
- R9: `irq` is registered. It is high one cycle after any overflow bit and its interrupt-enable bit are both 1, and low one cycle after no such pair exists.
- R10: When an overflow-clear write and a hardware overflow hit the same bit in the same cycle, the bit ends set.
- R11: `rdata` is registered. After a clock edge it holds the value the addressed register had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address (read and write) |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Registered read data |
| evt_pulse | input | NUM_EVT | Per-counter event pulses |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the bank with four event counters rather than the default eight. This leaves bits 4 to 30 of every mask unused, so writes to a missing bit can be seen to read back as zero. It also changes the count field in the control register to a value other than the default. Loading counters near all-ones brings both the 32-bit and the 64-bit wrap within a few cycles. One of those wraps is timed to land in the same cycle as an overflow-clear write. Random event patterns over 200 cycles, with one enabled-mask bit left off, check the counting against totals kept in the bench.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int REG_W   = 32;
  localparam int CYC_W   = 64;
  localparam int CYC_BIT = 31;
  localparam int CNT_FIELD_LSB = 11;
  localparam int CNT_FIELD_W   = 5;

  localparam int A_CTRL    = 'h00;
  localparam int A_EN_SET  = 'h01;
  localparam int A_EN_CLR  = 'h02;
  localparam int A_IE_SET  = 'h03;
  localparam int A_IE_CLR  = 'h04;
  localparam int A_OV_SET  = 'h05;
  localparam int A_OV_CLR  = 'h06;
  localparam int A_CYC_LO  = 'h08;
  localparam int A_CYC_HI  = 'h09;
  localparam int A_EVT0    = 'h10;

  localparam logic [REG_W-1:0] CTRL_CLEAR_ALL = 32'h6;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  // A load wins over counting; a wrap is only reported on a real advance.
  assign wrap = inc && !ld_en && (&cnt_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ld_en) cnt_q <= ld_val;
    else if (inc)   cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pcb_mask_reg.sv
module pcb_mask_reg #(
  parameter int             W     = 32,
  parameter logic [W-1:0]   VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, nxt;

  always_comb begin
    nxt = q_r;
    if (set_we) nxt = nxt | wdata;
    if (clr_we) nxt = nxt & ~wdata;
    nxt = (nxt | hw_set) & VALID;  // hardware set has the last word
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
  import pcb_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               we,
  output logic [REG_W-1:0]   rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);
  localparam logic [REG_W-1:0] EVT_MASK = REG_W'((64'd1 << NUM_EVT) - 64'd1);
  localparam logic [REG_W-1:0] VALID    = EVT_MASK | (REG_W'(1) << CYC_BIT);
  localparam logic [CNT_FIELD_W-1:0] NUM_FIELD = CNT_FIELD_W'(NUM_EVT);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // ---------------- write decode ----------------
  logic wr_ctrl, clr_all, wr_cyc_lo, wr_cyc_hi;
  assign wr_ctrl   = we && hit(addr, A_CTRL);
  assign clr_all   = wr_ctrl && (wdata == CTRL_CLEAR_ALL);
  assign wr_cyc_lo = we && hit(addr, A_CYC_LO);
  assign wr_cyc_hi = we && hit(addr, A_CYC_HI);

  logic glob_en;
  always_ff @(posedge clk) begin
    if (rst)          glob_en <= 1'b0;
    else if (wr_ctrl) glob_en <= wdata[0];
  end

  // ---------------- bitmask registers ----------------
  logic [REG_W-1:0] cnten_q, inten_q, ovf_q, ovf_hw;

  pcb_mask_reg #(.W(REG_W), .VALID(VALID)) u_cnten (
    .clk(clk), .rst(rst),
    .set_we(we && hit(addr, A_EN_SET)), .clr_we(we && hit(addr, A_EN_CLR)),
    .wdata(wdata), .hw_set('0), .q(cnten_q)
  );

  pcb_mask_reg #(.W(REG_W), .VALID(VALID)) u_inten (
    .clk(clk), .rst(rst),
    .set_we(we && hit(addr, A_IE_SET)), .clr_we(we && hit(addr, A_IE_CLR)),
    .wdata(wdata), .hw_set('0), .q(inten_q)
  );

  pcb_mask_reg #(.W(REG_W), .VALID(VALID)) u_ovf (
    .clk(clk), .rst(rst),
    .set_we(we && hit(addr, A_OV_SET)), .clr_we(we && hit(addr, A_OV_CLR)),
    .wdata(wdata), .hw_set(ovf_hw), .q(ovf_q)
  );

  // ---------------- event counters ----------------
  logic [REG_W-1:0]   evt_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap;

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    logic ld;
    assign ld = clr_all || (we && hit(addr, A_EVT0 + n));
    pcb_counter #(.W(REG_W)) u_cnt (
      .clk(clk), .rst(rst),
      .inc(glob_en && cnten_q[n] && evt_pulse[n]),
      .ld_en(ld), .ld_val(clr_all ? '0 : wdata),
      .cnt(evt_cnt[n]), .wrap(evt_wrap[n])
    );
  end

  // ---------------- cycle counter ----------------
  logic [CYC_W-1:0] cyc_cnt, cyc_ld_val;
  logic             cyc_wrap;

  always_comb begin
    if (clr_all)        cyc_ld_val = '0;
    else if (wr_cyc_lo) cyc_ld_val = {cyc_cnt[CYC_W-1:REG_W], wdata};
    else                cyc_ld_val = {wdata, cyc_cnt[REG_W-1:0]};
  end

  pcb_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst(rst),
    .inc(glob_en && cnten_q[CYC_BIT]),
    .ld_en(clr_all || wr_cyc_lo || wr_cyc_hi), .ld_val(cyc_ld_val),
    .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  always_comb begin
    ovf_hw = '0;
    ovf_hw[NUM_EVT-1:0] = evt_wrap;
    ovf_hw[CYC_BIT]     = cyc_wrap;
  end

  // ---------------- read mux and outputs ----------------
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(addr, A_CTRL)) begin
      rd_mux[0] = glob_en;
      rd_mux[CNT_FIELD_LSB +: CNT_FIELD_W] = NUM_FIELD;
    end
    if (hit(addr, A_EN_SET) || hit(addr, A_EN_CLR)) rd_mux = cnten_q;
    if (hit(addr, A_IE_SET) || hit(addr, A_IE_CLR)) rd_mux = inten_q;
    if (hit(addr, A_OV_SET) || hit(addr, A_OV_CLR)) rd_mux = ovf_q;
    if (hit(addr, A_CYC_LO)) rd_mux = cyc_cnt[REG_W-1:0];
    if (hit(addr, A_CYC_HI)) rd_mux = cyc_cnt[CYC_W-1:REG_W];
    for (int n = 0; n < NUM_EVT; n++)
      if (hit(addr, A_EVT0 + n)) rd_mux = evt_cnt[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_mux;
      irq   <= |(ovf_q & inten_q);
    end
  end
endmodule

// File: rtl/pcb_bank_chk.sv
module pcb_bank_chk
  import pcb_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic              irq,
  input logic              glob_en,
  input logic [REG_W-1:0]  cnten_q,
  input logic [REG_W-1:0]  inten_q,
  input logic [REG_W-1:0]  ovf_q,
  input logic [CYC_W-1:0]  cyc_cnt
);
  localparam logic [REG_W-1:0] VALID =
    REG_W'((64'd1 << NUM_EVT) - 64'd1) | (REG_W'(1) << CYC_BIT);

  logic cyc_touch;
  assign cyc_touch = we && (addr == ADDR_W'(A_CYC_LO) || addr == ADDR_W'(A_CYC_HI)
                            || addr == ADDR_W'(A_CTRL));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && !glob_en && cnten_q == '0 && inten_q == '0 && ovf_q == '0));

  assert_valid_bits_R3: assert property (@(posedge clk) disable iff (rst)
    ((cnten_q | inten_q | ovf_q) & ~VALID) == '0);

  assert_cyc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (glob_en && cnten_q[CYC_BIT] && !cyc_touch) |=> cyc_cnt == $past(cyc_cnt) + CYC_W'(1));

  assert_cyc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !we) |=> $stable(cyc_cnt));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_q[CYC_BIT] && !(we && addr == ADDR_W'(A_OV_CLR) && wdata[CYC_BIT])) |=> ovf_q[CYC_BIT]);

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
    (|(ovf_q & inten_q)) |=> irq);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(ovf_q & inten_q)) |=> !irq);

  // R10: a wrap sets the bit even when a clear write lands in the same cycle
  assert_ovf_hw_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (glob_en && cnten_q[CYC_BIT] && (&cyc_cnt) && !cyc_touch) |=> ovf_q[CYC_BIT]);
endmodule

bind pcb_bank pcb_bank_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .irq(irq),
  .glob_en(glob_en), .cnten_q(cnten_q), .inten_q(inten_q), .ovf_q(ovf_q),
  .cyc_cnt(cyc_cnt)
);

// File: tb/pcb_bank_bench.sv
module pcb_bank_bench;
  localparam int NE = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          we = 1'b0;
  logic [31:0]   rdata;
  logic [NE-1:0] evt_pulse = '0;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcb_bank #(.NUM_EVT(NE), .ADDR_W(AW)) u_pcb_bank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [31:0] ctrl_val(input logic en);
    return (32'(NE) << 11) | {31'b0, en};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // each task starts just after a falling edge and uses one rising edge
  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = AW'(a); we = 1'b0;
    @(posedge clk); #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_evt [NE];
    logic [31:0] a, b;
    logic [NE-1:0] v;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset state and counter-count field
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R2 ctrl", 'h00, ctrl_val(1'b0));
    rd_chk("R1 cnten", 'h01, 32'h0);
    rd_chk("R1 ovf", 'h05, 32'h0);
    rd_chk("R1 evt0", 'h10, 32'h0);
    rd_chk("R1 cyc_hi", 'h09, 32'h0);

    // R3: set/clear semantics, unused bits, zero bits ignored
    wr('h01, 32'h8000_0025);
    rd_chk("R3 set unused bit dropped", 'h01, 32'h8000_0005);
    wr('h02, 32'h0);
    rd_chk("R3 zero clear ignored", 'h02, 32'h8000_0005);
    wr('h02, 32'h8000_0001);
    rd_chk("R3 clear", 'h01, 32'h0000_0004);
    wr('h02, 32'h4);
    wr('h03, 32'h0);
    rd_chk("R3 zero set ignored", 'h03, 32'h0);

    // R6: loads
    wr('h12, 32'h1234_5678);
    rd_chk("R6 evt2 load", 'h12, 32'h1234_5678);
    wr('h08, 32'hDEAD_BEEF);
    wr('h09, 32'h0000_0001);
    rd_chk("R6 cyc lo", 'h08, 32'hDEAD_BEEF);
    rd_chk("R6 cyc hi", 'h09, 32'h0000_0001);

    // R4: random event pulses, counter 3 left disabled
    for (int i = 0; i < NE; i++) begin
      exp_evt[i] = $urandom_range(32'h00FF_FFFF, 0);
      wr('h10 + i, exp_evt[i]);
    end
    wr('h01, 32'h7);
    wr('h00, 32'h1);
    for (int c = 0; c < 200; c++) begin
      v = NE'($urandom);
      evt_pulse = v;
      @(negedge clk);
      for (int i = 0; i < 3; i++) exp_evt[i] += 32'(v[i]);
    end
    evt_pulse = '0;
    wr('h00, 32'h0);
    for (int i = 0; i < NE; i++) rd_chk($sformatf("R4 evt%0d", i), 'h10 + i, exp_evt[i]);
    rd_chk("R4 no overflow", 'h05, 32'h0);
    rd_chk("R5 cyc held while its bit is off", 'h08, 32'hDEAD_BEEF);

    // R5 / R8: 64-bit wrap after five enabled edges
    wr('h08, 32'hFFFF_FFFD);
    wr('h09, 32'hFFFF_FFFF);
    wr('h01, 32'h8000_0000);
    wr('h00, 32'h1);
    repeat (4) @(negedge clk);
    wr('h00, 32'h0);
    rd_chk("R5 cyc lo after wrap", 'h08, 32'h2);
    rd_chk("R5 cyc hi after wrap", 'h09, 32'h0);
    rd_chk("R8 cyc ovf", 'h05, 32'h8000_0000);
    check("R9 irq masked", {31'b0, irq}, 32'h0);

    // R9: registered interrupt
    wr('h03, 32'h8000_0000);
    check("R9 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr('h06, 32'h8000_0000);
    @(negedge clk);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    rd_chk("R8 ovf cleared", 'h05, 32'h0);

    // R10: event wrap and clear write in the same cycle
    wr('h02, 32'h8000_0000);
    wr('h11, 32'hFFFF_FFFF);
    wr('h00, 32'h1);
    addr = AW'('h06); wdata = 32'h2; we = 1'b1; evt_pulse = 4'b0010;
    @(negedge clk);
    we = 1'b0; evt_pulse = '0;
    wr('h00, 32'h0);
    rd_chk("R8 evt1 wrapped", 'h11, 32'h0);
    rd_chk("R10 hw set beats clear", 'h05, 32'h2);
    wr('h06, 32'h2);
    rd_chk("R8 evt ovf cleared", 'h05, 32'h0);

    // R7: clear-all
    wr('h00, 32'h1);
    wr('h00, 32'h6);
    for (int i = 0; i < NE; i++) rd_chk($sformatf("R7 evt%0d zero", i), 'h10 + i, 32'h0);
    rd_chk("R7 cyc zero", 'h08, 32'h0);
    rd_chk("R7 enable cleared", 'h00, ctrl_val(1'b0));

    // R11: back-to-back reads of a running counter
    wr('h01, 32'h8000_0000);
    wr('h00, 32'h1);
    rd('h08, a);
    rd('h08, b);
    check("R11 read latency", b, a + 32'h1);
    rd_chk("R2 ctrl enable", 'h00, ctrl_val(1'b1));
    wr('h00, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule